// File: doc/BRIEF.md
# Gateway Privilege Promotion Unit

This unit holds the processor's current privilege level and changes it only along two sanctioned paths. Level 0 is the most privileged and level 3 the least. The first path is a gateway instruction, which raises privilege. The second is a return request, which lowers privilege or keeps it the same.

For a gateway, the target level and the right to use a gateway both come from attributes of the page the instruction was fetched from, not from the instruction itself. Two gateway kinds exist. One promotes and also asks the fetch logic to redirect. The other only promotes.

A gateway never lowers privilege. If a return names a level more privileged than the one now executing, it is treated as a spoofing attempt and faults. Every decision is registered and shows at the outputs on the clock edge after the strobe.

Top module: `gw_priv_unit`

## Requirements
- R1: After reset, privLvl is 0, fault is 0, faultCause is 2'b00 (none) and redirect is 0.
- R2: A gateway strobe on a page with gateway permission and a target level numerically below the current level loads privLvl with the target on the next clock edge, with no fault.
- R3: A permitted gateway whose target level is equal to or numerically above the current level leaves privLvl unchanged and raises no fault.
- R4: A gateway strobe on a page without gateway permission raises fault for one cycle with faultCause 2'b01, leaves privLvl unchanged and gives no redirect.
- R5: A permitted gateway of the branching kind (gateKind=0) pulses redirect for one cycle. The promote-only kind (gateKind=1) gives no redirect but has the same effect on privilege.
- R6: A return strobe whose requested level is equal to or numerically above the current level loads privLvl with that level, with no fault.
- R7: A return strobe whose requested level is numerically below the current level raises fault for one cycle with faultCause 2'b10 and leaves privLvl unchanged.
- R8: When a gateway strobe and a return strobe arrive in the same cycle, the gateway is acted on and the return is ignored.
- R9: In a cycle with no strobe, privLvl holds, and on the next edge fault, faultCause and redirect return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateStrobe | input | 1 | A gateway instruction is executing |
| gateKind | input | 1 | 0 = promote and redirect, 1 = promote only |
| pageGateOk | input | 1 | The fetching page permits gateways |
| pageTargetLvl | input | 2 | Promotion level from the fetching page |
| retStrobe | input | 1 | A return that carries a privilege level |
| retLvl | input | 2 | Requested return level |
| privLvl | output | 2 | Current privilege level |
| fault | output | 1 | One-cycle fault pulse |
| faultCause | output | 2 | 00 none, 01 illegal gateway, 10 spoofed return |
| redirect | output | 1 | One-cycle pulse for an accepted branching gateway |

## Verification
Gateways are tried at every pairing of current level and page target. This separates real promotion from the held "no demote" case, and shows where the two cases meet when the levels are equal. Returns are tried above, at, and below the current level, which separates a legal drop, the equal-level boundary and the spoof fault. Further cases cover a gateway on a page without permission, both gateway kinds, and simultaneous strobes. Together these confirm the fault cause encoding, the redirect behaviour and the priority rule.

// File: rtl/gw_priv_pkg.sv
package gw_priv_pkg;
  parameter int NUM_LVL = 4;
  localparam int LVL_W = $clog2(NUM_LVL);

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_GATE  = 2'b01,
    CAUSE_SPOOF = 2'b10
  } cause_e;

  typedef enum logic [1:0] {
    SEL_HOLD = 2'b00,
    SEL_PAGE = 2'b01,
    SEL_RET  = 2'b10
  } lvl_sel_e;

  typedef struct packed {
    lvl_sel_e lvlSel;
    logic     raiseFault;
    cause_e   cause;
    logic     redirect;
  } gw_strobes_t;
endpackage

// File: rtl/gw_priv_ctrl.sv
module gw_priv_ctrl
  import gw_priv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        gateStrobe,
  input  logic        gateKind,
  input  logic        pageGateOk,
  input  lvl_t        pageTargetLvl,
  input  logic        retStrobe,
  input  lvl_t        retLvl,
  input  lvl_t        curLvl,
  input  logic        faultQ,
  input  cause_e      causeQ,
  output gw_strobes_t strobes
);
  logic gateLegal;
  logic gatePromotes;
  logic retSpoof;

  assign gateLegal    = gateStrobe && pageGateOk;
  assign gatePromotes = pageTargetLvl < curLvl;
  assign retSpoof     = retLvl < curLvl;

  always_comb begin
    strobes = '{lvlSel: SEL_HOLD, raiseFault: 1'b0, cause: CAUSE_NONE, redirect: 1'b0};
    if (gateStrobe) begin
      if (!gateLegal) begin
        strobes.raiseFault = 1'b1;
        strobes.cause      = CAUSE_GATE;
      end else begin
        if (gatePromotes) strobes.lvlSel = SEL_PAGE;
        strobes.redirect = !gateKind;
      end
    end else if (retStrobe) begin
      if (retSpoof) begin
        strobes.raiseFault = 1'b1;
        strobes.cause      = CAUSE_SPOOF;
      end else begin
        strobes.lvlSel = SEL_RET;
      end
    end
  end

  AST_ILLEGAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (gateStrobe && !pageGateOk) |=> (faultQ && causeQ == CAUSE_GATE)); // R4
  AST_SPOOF_RET: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !gateStrobe && retLvl < curLvl) |=> (faultQ && causeQ == CAUSE_SPOOF)); // R7
  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!gateStrobe && !retStrobe) |=> !faultQ); // R9
endmodule

// File: rtl/gw_priv_dp.sv
module gw_priv_dp
  import gw_priv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  gw_strobes_t strobes,
  input  lvl_t        pageTargetLvl,
  input  lvl_t        retLvl,
  input  logic        gateStrobe,
  output lvl_t        lvlQ,
  output logic        faultQ,
  output cause_e      causeQ,
  output logic        redirQ
);
  lvl_t lvlD;

  always_comb begin
    unique case (strobes.lvlSel)
      SEL_PAGE: lvlD = pageTargetLvl;
      SEL_RET:  lvlD = retLvl;
      default:  lvlD = lvlQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvlQ   <= '0;
      faultQ <= 1'b0;
      causeQ <= CAUSE_NONE;
      redirQ <= 1'b0;
    end else begin
      lvlQ   <= lvlD;
      faultQ <= strobes.raiseFault;
      causeQ <= strobes.cause;
      redirQ <= strobes.redirect;
    end
  end

  AST_GATE_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rstN)
    $past(gateStrobe) |-> (lvlQ <= $past(lvlQ))); // R3
  AST_FAULT_KEEPS_LVL: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (lvlQ == $past(lvlQ))); // R7
  AST_REDIRECT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    redirQ |-> !faultQ); // R5
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !faultQ |-> (causeQ == CAUSE_NONE)); // R9
endmodule

// File: rtl/gw_priv_unit.sv
module gw_priv_unit
  import gw_priv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             gateStrobe,
  input  logic             gateKind,
  input  logic             pageGateOk,
  input  logic [LVL_W-1:0] pageTargetLvl,
  input  logic             retStrobe,
  input  logic [LVL_W-1:0] retLvl,
  output logic [LVL_W-1:0] privLvl,
  output logic             fault,
  output logic [1:0]       faultCause,
  output logic             redirect
);
  gw_strobes_t strobes;
  lvl_t        lvlQ;
  logic        faultQ;
  cause_e      causeQ;
  logic        redirQ;

  gw_priv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .gateStrobe(gateStrobe), .gateKind(gateKind), .pageGateOk(pageGateOk),
    .pageTargetLvl(pageTargetLvl), .retStrobe(retStrobe), .retLvl(retLvl),
    .curLvl(lvlQ), .faultQ(faultQ), .causeQ(causeQ), .strobes(strobes)
  );

  gw_priv_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pageTargetLvl(pageTargetLvl), .retLvl(retLvl), .gateStrobe(gateStrobe),
    .lvlQ(lvlQ), .faultQ(faultQ), .causeQ(causeQ), .redirQ(redirQ)
  );

  assign privLvl    = lvlQ;
  assign fault      = faultQ;
  assign faultCause = causeQ;
  assign redirect   = redirQ;

  AST_BOTH_GATE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (gateStrobe && retStrobe && pageGateOk && pageTargetLvl >= privLvl) |=> (privLvl == $past(privLvl) && !fault)); // R8
endmodule

// File: tb/tb_gw_priv_unit.sv
module tb_gw_priv_unit;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       gateStrobe = 1'b0, gateKind = 1'b0, pageGateOk = 1'b0, retStrobe = 1'b0;
  logic [1:0] pageTargetLvl = '0, retLvl = '0;
  logic [1:0] privLvl, faultCause;
  logic       fault, redirect;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct packed {
    logic [1:0] lvl;
    logic       flt;
    logic [1:0] cause;
    logic       redir;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  logic [1:0] mLvl = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gw_priv_unit dut (
    .clk(clk), .rstN(rstN), .gateStrobe(gateStrobe), .gateKind(gateKind),
    .pageGateOk(pageGateOk), .pageTargetLvl(pageTargetLvl), .retStrobe(retStrobe),
    .retLvl(retLvl), .privLvl(privLvl), .fault(fault), .faultCause(faultCause),
    .redirect(redirect)
  );

  task automatic compare(string tag, exp_t e);
    checks++;
    if (privLvl !== e.lvl || fault !== e.flt || faultCause !== e.cause || redirect !== e.redir) begin
      errors++;
      $display("FAIL %s: got lvl=%0d fault=%0b cause=%0d redir=%0b, expected lvl=%0d fault=%0b cause=%0d redir=%0b",
               tag, privLvl, fault, faultCause, redirect, e.lvl, e.flt, e.cause, e.redir);
    end
  endtask

  // Driver: applies one cycle of stimulus and predicts from the requirements
  task automatic step(bit g, bit k, bit ok, logic [1:0] tgt, bit r, logic [1:0] rl, string tag);
    exp_t e;
    @(negedge clk);
    gateStrobe = g; gateKind = k; pageGateOk = ok; pageTargetLvl = tgt;
    retStrobe = r; retLvl = rl;
    e = '{lvl: mLvl, flt: 1'b0, cause: 2'b00, redir: 1'b0};
    if (g) begin
      if (!ok) begin e.flt = 1'b1; e.cause = 2'b01; end
      else begin
        if (tgt < mLvl) e.lvl = tgt;
        e.redir = !k;
      end
    end else if (r) begin
      if (rl < mLvl) begin e.flt = 1'b1; e.cause = 2'b10; end
      else e.lvl = rl;
    end
    mLvl = e.lvl;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares one queued prediction after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) compare(tagQ.pop_front(), expQ.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got no completion, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset", '{lvl: 2'd0, flt: 1'b0, cause: 2'b00, redir: 1'b0});
    @(negedge clk);
    rstN = 1'b1;
    step(0, 0, 0, 0, 1, 3, "R6 return to 3");
    step(1, 0, 1, 1, 0, 0, "R2 R5 branching gateway to 1");
    step(1, 0, 1, 2, 0, 0, "R3 gateway target less privileged");
    step(0, 0, 0, 0, 1, 0, "R7 spoofed return");
    step(0, 0, 0, 0, 0, 0, "R9 idle clears");
    step(1, 0, 0, 0, 0, 0, "R4 gateway without permission");
    step(0, 0, 0, 0, 1, 2, "R6 return to 2");
    step(1, 1, 1, 0, 0, 0, "R5 promote-only gateway to 0");
    step(0, 0, 0, 0, 1, 3, "R6 return to 3");
    step(1, 0, 1, 2, 1, 3, "R8 gateway wins over return");
    step(1, 0, 0, 1, 1, 3, "R8 illegal gateway wins over return");
    step(0, 0, 0, 0, 1, 2, "R6 return to equal level");
    step(0, 0, 0, 0, 0, 0, "R9 idle holds level");
    for (int c = 0; c < 4; c++) begin
      for (int t = 0; t < 4; t++) begin
        step(0, 0, 0, 0, 1, 3, "R6 sweep setup");
        if (c < 3) step(1, 1, 1, c[1:0], 0, 0, "R2 sweep set current");
        step(1, t[0], 1, t[1:0], 0, 0, "R2 R3 sweep gateway");
        step(0, 0, 0, 0, 1, c[1:0], "R6 R7 sweep return");
      end
    end
    step(0, 0, 0, 0, 0, 0, "R9 final idle");
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule